// File: doc/BRIEF.md
# Serial Frame Sync Generator

This block derives the word and frame timing of a synchronous serial port from a bit-clock enable. A word stage counts bit enables and closes a word every 8, 12, 16, 24 or 32 bits. A frame stage counts finished words and closes a frame after a programmable number of them. From these two counters the block drives three outputs. The first is a word-boundary strobe. The second is a frame-sync pulse that lasts either one bit or one whole word. The third is an indication that the port is running on demand, with no periodic frame sync.

The divide-control value has a different meaning in each mode. In network mode it gives the number of slots per frame, minus one. In normal mode it sets how often a word is transferred, and zero gives back-to-back words with a sync on every word. A zero value in network mode selects on-demand operation instead. In normal mode with a zero value, any sync length other than one bit is reported as a configuration error.

Every configuration input is captured only at a frame boundary, so a running frame is never cut short.

Top module: `fsync_gen`

## Requirements
- R1: The word-length code selects the bits per word W: code 0 gives 8, code 1 gives 12, code 2 gives 16, code 3 gives 24, and codes 4 to 7 give 32. The wordStrobe output is high for exactly one clock, in the cycle after the bitEn cycle that completes a word.
- R2: A frame lasts (divCtl+1) words. This holds in both modes for divCtl values 1 to 31.
- R3: In network mode (netMode=1) with divCtl=0, onDemand is high and frameSync stays low. Words keep being counted.
- R4: In normal mode (netMode=0) with divCtl=0, every word is a frame. A one-bit frame sync occurs in the last bit period of every word.
- R5: cfgErr is high exactly when the active configuration is normal mode, divCtl=0 and a sync length code other than 01. While cfgErr is high, frameSync is held low.
- R6: With sync length code 01 (bit-length), frameSync is high for only the last bit period of each frame, which is the bit period just before the first bit of slot 0.
- R7: With any sync length code other than 01 (word-length), frameSync is high from the last bit period of a frame through the first W-1 bit periods of slot 0. That is a span of W bit periods.
- R8: divCtl, netMode, wlCode and fsLen are sampled only by the bitEn cycle that completes a frame. A change made in the middle of a frame does not alter the frame in progress.
- R9: After reset the active configuration is divCtl=0, normal mode, W=8 and bit-length sync. Both counters are at zero, and all four outputs are low.
- R10: In a cycle that follows a cycle with bitEn low, the counters do not advance, wordStrobe is low and frameSync keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bitEn | input | 1 | One-cycle enable per serial bit period |
| divCtl | input | 5 | Frame divide control; the ratio is divCtl+1 |
| netMode | input | 1 | 1 = network mode, 0 = normal mode |
| wlCode | input | 3 | Word-length code (see R1) |
| fsLen | input | 2 | Sync length: 01 = one bit, any other code = one word |
| wordStrobe | output | 1 | One-clock pulse after each completed word |
| frameSync | output | 1 | Frame-sync pulse |
| onDemand | output | 1 | Network mode with a zero divide value is active |
| cfgErr | output | 1 | Illegal sync length in normal mode with a zero divide value |

## Verification
The hardest situation to reach is a configuration change that arrives in the middle of a frame. The old frame must finish at its full length, and the new word length and ratio must apply from the very next bit. The bench starts a four-slot network frame. Partway through a slot it changes the divide value, the word length and the sync length all at once. It then checks every bit against a position tracker that reloads its settings only at the frame-completing bit. Gapped bit enables check, on the same tracker, that idle cycles leave every output frozen.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
  localparam int DC_W     = 5;
  localparam int WL_W     = 3;
  localparam int FSL_W    = 2;
  localparam int WORD_MAX = 32;
  localparam int BIT_W    = $clog2(WORD_MAX);

  localparam logic [FSL_W-1:0] FSL_BIT = FSL_W'(1);

  typedef struct packed {
    logic [DC_W-1:0]  dc;
    logic             net;
    logic [WL_W-1:0]  wl;
    logic [FSL_W-1:0] fsl;
  } cfg_t;

  typedef struct packed {
    logic step;
    logic wordEnd;
    logic frameEnd;
  } strobe_t;

  // Index of the last bit of a word for a given word-length code
  function automatic logic [BIT_W-1:0] lastBitOf(input logic [WL_W-1:0] code);
    case (code)
      WL_W'(0): lastBitOf = BIT_W'(7);
      WL_W'(1): lastBitOf = BIT_W'(11);
      WL_W'(2): lastBitOf = BIT_W'(15);
      WL_W'(3): lastBitOf = BIT_W'(23);
      default:  lastBitOf = BIT_W'(WORD_MAX - 1);
    endcase
  endfunction
endpackage

// File: rtl/fsg_ctrl.sv
module fsg_ctrl
  import fsg_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  bitEn,
  input  logic [DC_W-1:0]       divCtl,
  input  logic                  netMode,
  input  logic [WL_W-1:0]       wlCode,
  input  logic [FSL_W-1:0]      fsLen,
  input  logic                  bitLast,
  input  logic                  slotLast,
  output cfg_t                  actCfg,
  output logic [BIT_W-1:0]      lastBit,
  output logic [DC_W-1:0]       lastSlot,
  output strobe_t               strb
);
  // Active configuration, reloaded only at frame completion (R8, R9)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actCfg.dc  <= '0;
      actCfg.net <= 1'b0;
      actCfg.wl  <= '0;
      actCfg.fsl <= FSL_BIT;
    end else if (strb.frameEnd) begin
      actCfg.dc  <= divCtl;
      actCfg.net <= netMode;
      actCfg.wl  <= wlCode;
      actCfg.fsl <= fsLen;
    end
  end

  always_comb begin
    lastBit       = lastBitOf(actCfg.wl);
    lastSlot      = actCfg.dc;
    strb.step     = bitEn;
    strb.wordEnd  = bitEn && bitLast;
    strb.frameEnd = bitEn && bitLast && slotLast;
  end
endmodule

// File: rtl/fsg_count.sv
module fsg_count
  import fsg_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [BIT_W-1:0] lastBit,
  input  logic [DC_W-1:0]  lastSlot,
  output logic             bitLast,
  output logic             slotLast,
  output logic             slotZero,
  output logic             wordStrobe
);
  logic [BIT_W-1:0] bitCnt;
  logic [DC_W-1:0]  slotCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt     <= '0;
      slotCnt    <= '0;
      wordStrobe <= 1'b0;
    end else begin
      wordStrobe <= strb.wordEnd;
      if (strb.frameEnd) begin
        bitCnt  <= '0;
        slotCnt <= '0;
      end else if (strb.wordEnd) begin
        bitCnt  <= '0;
        slotCnt <= slotCnt + DC_W'(1);
      end else if (strb.step) begin
        bitCnt  <= bitCnt + BIT_W'(1);
      end
    end
  end

  always_comb begin
    bitLast  = (bitCnt == lastBit);
    slotLast = (slotCnt == lastSlot);
    slotZero = (slotCnt == '0);
  end
endmodule

// File: rtl/fsg_shape.sv
module fsg_shape
  import fsg_pkg::*;
(
  input  cfg_t actCfg,
  input  logic bitLast,
  input  logic slotLast,
  input  logic slotZero,
  output logic frameSync,
  output logic onDemand,
  output logic cfgErr
);
  logic lead;
  logic wordSpan;

  always_comb begin
    onDemand = actCfg.net && (actCfg.dc == '0);
    cfgErr   = !actCfg.net && (actCfg.dc == '0) && (actCfg.fsl != FSL_BIT);
    lead     = bitLast && slotLast;
    wordSpan = lead || (slotZero && !bitLast);
    if (onDemand || cfgErr)
      frameSync = 1'b0;
    else if (actCfg.fsl == FSL_BIT)
      frameSync = lead;
    else
      frameSync = wordSpan;
  end
endmodule

// File: rtl/fsync_gen.sv
module fsync_gen
  import fsg_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitEn,
  input  logic [DC_W-1:0]  divCtl,
  input  logic             netMode,
  input  logic [WL_W-1:0]  wlCode,
  input  logic [FSL_W-1:0] fsLen,
  output logic             wordStrobe,
  output logic             frameSync,
  output logic             onDemand,
  output logic             cfgErr
);
  cfg_t             actCfg;
  strobe_t          strb;
  logic [BIT_W-1:0] lastBit;
  logic [DC_W-1:0]  lastSlot;
  logic             bitLast;
  logic             slotLast;
  logic             slotZero;

  fsg_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .divCtl(divCtl),
    .netMode(netMode), .wlCode(wlCode), .fsLen(fsLen),
    .bitLast(bitLast), .slotLast(slotLast), .actCfg(actCfg),
    .lastBit(lastBit), .lastSlot(lastSlot), .strb(strb)
  );

  fsg_count count_i (
    .clk(clk), .rstN(rstN), .strb(strb), .lastBit(lastBit),
    .lastSlot(lastSlot), .bitLast(bitLast), .slotLast(slotLast),
    .slotZero(slotZero), .wordStrobe(wordStrobe)
  );

  fsg_shape shape_i (
    .actCfg(actCfg), .bitLast(bitLast), .slotLast(slotLast),
    .slotZero(slotZero), .frameSync(frameSync), .onDemand(onDemand),
    .cfgErr(cfgErr)
  );
endmodule

// File: rtl/fsync_gen_chk.sv
module fsync_gen_chk
  import fsg_pkg::*;
(
  input logic clk,
  input logic rstN,
  input logic bitEn,
  input logic wordStrobe,
  input logic frameSync,
  input logic onDemand,
  input logic cfgErr,
  input cfg_t actCfg
);
  assert_strobe_single_R1: assert property (@(posedge clk) disable iff (!rstN)
    wordStrobe |=> !wordStrobe);

  assert_ondemand_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
    onDemand |-> !frameSync);

  assert_err_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |-> !frameSync);

  assert_bit_len_R6: assert property (@(posedge clk) disable iff (!rstN)
    (frameSync && bitEn && actCfg.fsl == FSL_BIT) |=> (!frameSync || actCfg.fsl != FSL_BIT));

  assert_cfg_at_frame_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(actCfg) |-> wordStrobe);

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !$past(bitEn) |-> ($stable(frameSync) && !wordStrobe));
endmodule

bind fsync_gen fsync_gen_chk chk_i (
  .clk(clk), .rstN(rstN), .bitEn(bitEn), .wordStrobe(wordStrobe),
  .frameSync(frameSync), .onDemand(onDemand), .cfgErr(cfgErr), .actCfg(actCfg)
);

// File: tb/fsync_gen_tb_top.sv
`timescale 1ns/1ps
module fsync_gen_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitEn = 1'b0;
  logic [4:0] divCtl = '0;
  logic       netMode = 1'b0;
  logic [2:0] wlCode = '0;
  logic [1:0] fsLen = 2'b01;
  logic       wordStrobe, frameSync, onDemand, cfgErr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Position tracker built from the requirements
  int mPos, mW, mD, mNet, mFsl;
  bit expWs;

  always #5 clk = ~clk;

  fsync_gen dut_i (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .divCtl(divCtl), .netMode(netMode),
    .wlCode(wlCode), .fsLen(fsLen), .wordStrobe(wordStrobe), .frameSync(frameSync),
    .onDemand(onDemand), .cfgErr(cfgErr)
  );

  function automatic int wordBits(input int code);
    case (code)
      0: return 8;
      1: return 12;
      2: return 16;
      3: return 24;
      default: return 32;
    endcase
  endfunction

  task automatic compare(input string tag);
    bit onD, err, bLast, sLast, fs;
    int s, b;
    onD   = (mNet == 1) && (mD == 0);
    err   = (mNet == 0) && (mD == 0) && (mFsl != 1);
    b     = mPos % mW;
    s     = mPos / mW;
    bLast = (b == mW - 1);
    sLast = (s == mD);
    if (onD || err)   fs = 1'b0;
    else if (mFsl == 1) fs = bLast && sLast;
    else              fs = (bLast && sLast) || (s == 0 && !bLast);
    checks++;
    if ({wordStrobe, frameSync, onDemand, cfgErr} !== {expWs, fs, onD, err}) begin
      fails++;
      $display("FAIL %s pos=%0d {ws,fs,od,err} actual=%b%b%b%b expected=%b%b%b%b",
               tag, mPos, wordStrobe, frameSync, onDemand, cfgErr, expWs, fs, onD, err);
    end
  endtask

  // Called at a negedge; returns at the following negedge after checking
  task automatic step(input bit en, input string tag);
    bitEn = en;
    @(posedge clk);
    expWs = 1'b0;
    if (en) begin
      if (mPos % mW == mW - 1) expWs = 1'b1;
      if (mPos == mW * (mD + 1) - 1) begin
        mPos = 0;
        mD   = int'(divCtl);
        mNet = int'(netMode);
        mW   = wordBits(int'(wlCode));
        mFsl = int'(fsLen);
      end else begin
        mPos++;
      end
    end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic run(input int n, input string tag, input bit gaps);
    for (int i = 0; i < n; i++) step(gaps ? (i % 3 != 1) : 1'b1, tag);
  endtask

  task automatic doReset(input int dc, input bit net, input int wl, input int fsl);
    @(negedge clk);
    rstN = 1'b0; bitEn = 1'b0;
    divCtl = 5'(dc); netMode = net; wlCode = 3'(wl); fsLen = 2'(fsl);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    mPos = 0; mW = 8; mD = 0; mNet = 0; mFsl = 1; expWs = 1'b0;
  endtask

  task automatic testReset();
    doReset(0, 0, 0, 1);
    compare("R9 reset state");
    run(20, "R9 default config", 1'b0);
  endtask

  task automatic testWordCodes();
    for (int c = 0; c < 8; c++) begin
      doReset(1, 1, c, 1);
      run(8 + 3 * wordBits(c), "R1 word length", 1'b0);
    end
  endtask

  task automatic testNormalRatio();
    doReset(3, 0, 0, 1);
    run(8 + 3 * 32, "R2 R6 normal ratio 4", 1'b0);
    doReset(31, 0, 0, 1);
    run(8 + 300, "R2 ratio 32", 1'b0);
  endtask

  task automatic testNetWordSync();
    doReset(2, 1, 1, 0);
    run(8 + 2 * 36, "R7 word sync", 1'b0);
    doReset(1, 1, 0, 3);
    run(8 + 40, "R7 word sync code 11", 1'b0);
  endtask

  task automatic testOnDemand();
    doReset(0, 1, 2, 1);
    run(8 + 50, "R3 on demand", 1'b0);
  endtask

  task automatic testNormalDc0();
    doReset(0, 0, 1, 1);
    run(8 + 48, "R4 continuous", 1'b0);
  endtask

  task automatic testCfgErr();
    doReset(0, 0, 0, 2);
    run(8 + 24, "R5 config error", 1'b0);
    fsLen = 2'b01;
    run(16, "R5 error cleared at boundary", 1'b0);
  endtask

  task automatic testMidFrame();
    doReset(3, 1, 0, 1);
    run(8 + 13, "R8 before change", 1'b0);
    divCtl = 5'd1; wlCode = 3'd2; fsLen = 2'b00;
    run(19 + 3 * 32, "R8 change mid frame", 1'b0);
  endtask

  task automatic testGaps();
    doReset(2, 1, 0, 0);
    run(90, "R10 idle gaps", 1'b1);
  endtask

  initial begin
    testReset();
    testWordCodes();
    testNormalRatio();
    testNetWordSync();
    testOnDemand();
    testNormalDc0();
    testCfgErr();
    testMidFrame();
    testGaps();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule